// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers 96 maskable interrupt lines and one non-maskable line. It picks the most urgent request that is both pending and enabled, and presents that request to a processor as a request flag with a vector number. The processor answers with an acknowledge strobe when it starts a handler and an end-of-interrupt strobe when the handler finishes. Between those two strobes the line counts as active. An internal stack of active lines lets a more urgent interrupt nest on top of a less urgent one.

Software programs the controller through a small word-addressed register bus with a single-cycle write strobe and a combinational read port. Each line has an 8-bit priority and a sense selection, which is level or rising edge. Enable and pending state each have a set bank and a clear bank. A split register divides every priority value into a group part and a subpriority part. Only the group part decides preemption. The subpriority still orders requests within a group.

Top module: `irqc_top`

## Requirements
- R1: After reset, every enable, pending, active, sense and priority bit reads 0, the split register reads 0, and no request is raised.
- R2: Among lines that are pending, enabled and not active, the one with the numerically smallest priority is requested, and `irq_vec_o` carries its line number. On equal priority the lower line number wins. An active line is never requested.
- R3: Writing ones to word `0x100+4k` enables lines `32k..32k+31`, and writing ones to `0x180+4k` disables them. Zero bits change nothing. Both addresses read back the current enable bits. A disabled line is never requested, even when it is pending.
- R4: Writing ones to word `0x200+4k` makes lines pending, and writing ones to `0x280+4k` cancels pending. Both addresses read the current pending bits.
- R5: A line whose sense bit is 0 (level) becomes pending whenever its input is high and the line is not active. If the input is still high after end-of-interrupt, the line becomes pending again.
- R6: Word `0x380+4k` holds the sense bits, where 1 means rising edge. An edge line becomes pending only on a 0-to-1 change of its input, so holding the input high does not re-pend it. An edge that arrives while the line is active is kept as pending.
- R7: An acknowledge while a maskable request is raised clears that line's pending bit, sets its active bit and pushes it on the nesting stack. The active bank at `0x300+4k` is read-only, and writes to it change nothing.
- R8: An end-of-interrupt clears the active bit of the most recently acknowledged line.
- R9: Word `0x400+4k` holds the priorities of lines `4k..4k+3`, with line `4k+b` in bits `[8b+7:8b]`. A new priority value is used in the first arbitration after the write.
- R10: The split register at `0x010`, bits `[2:0]` = S, makes the low S bits of a priority the subpriority. While a line is active, a new line is requested only if its group (priority >> S) is strictly smaller than the group of the line on top of the stack.
- R11: A rising edge on `nmi_i` is latched. It is then requested with vector 96 ahead of every maskable line, and no enable bit can mask it. While that request is being serviced, no other request is raised, and the next end-of-interrupt ends the non-maskable service first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 96 | Maskable interrupt lines, synchronous to clk |
| nmi_i | input | 1 | Non-maskable interrupt input, rising-edge latched |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address, word aligned |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for `bus_addr_i`, combinational |
| irq_req_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | 7 | Requested vector: line number, or 96 for the non-maskable input |
| irq_ack_i | input | 1 | Processor takes the requested vector |
| irq_eoi_i | input | 1 | Processor finished the current handler; never in the same cycle as `irq_ack_i` |

## Verification
The bench sweeps one contender's priority across all 256 values against a fixed rival. A comparator that uses `<=` where strict ordering is needed, or that ignores the lower-index tie rule, then requests the wrong line at value 128. It also walks every split setting against candidate priorities on both sides of the active line's group boundary. This exposes a design that compares full priorities, or that compares with the wrong field width, by a preemption decision that appears or vanishes at the wrong S. Level and edge lines are held high across acknowledge and end-of-interrupt. A design that mixes up the two senses either loses the re-pend of a level line or floods an edge line with repeated pending. A byte-mapped priority word with four distinct values catches swapped byte lanes. The non-maskable input is checked with every enable cleared, and while its service is in progress it must hide maskable requests.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned BUS_AW  = 12;
    localparam int unsigned BUS_DW  = 32;
    localparam int unsigned PRIO_W  = 8;
    localparam int unsigned SPLIT_W = 3;
    localparam int unsigned SEL_W   = 8;

    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [SPLIT_W-1:0] split_t;

    typedef enum logic [3:0] {
        RB_NONE,
        RB_EN_SET,
        RB_EN_CLR,
        RB_PD_SET,
        RB_PD_CLR,
        RB_ACT,
        RB_SENSE,
        RB_PRIO,
        RB_SPLIT
    } bank_e;

    typedef struct packed {
        bank_e             bank;
        logic [SEL_W-1:0]  word;
    } reg_sel_t;

    // group portion of a priority for a given split point
    function automatic prio_t group_of(prio_t p, split_t s);
        return p >> s;
    endfunction

    function automatic reg_sel_t decode_addr(logic [BUS_AW-1:0] a);
        reg_sel_t r;
        r.bank = RB_NONE;
        r.word = {3'b000, a[6:2]};
        if (a == 12'h010) begin
            r.bank = RB_SPLIT;
            r.word = '0;
        end else begin
            case (a[11:7])
                5'h02:   r.bank = RB_EN_SET;
                5'h03:   r.bank = RB_EN_CLR;
                5'h04:   r.bank = RB_PD_SET;
                5'h05:   r.bank = RB_PD_CLR;
                5'h06:   r.bank = RB_ACT;
                5'h07:   r.bank = RB_SENSE;
                5'h08, 5'h09, 5'h0A, 5'h0B,
                5'h0C, 5'h0D, 5'h0E, 5'h0F: begin
                    r.bank = RB_PRIO;
                    r.word = a[9:2];
                end
                default: r.bank = RB_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned N = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] edge_mode_i,
    input  logic [N-1:0] act_i,
    input  logic [N-1:0] ack_hit_i,
    input  logic [N-1:0] sw_set_i,
    input  logic [N-1:0] sw_clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic hw_set;
        // edge lines: a fresh rising edge, even while active
        // level lines: input high and line not in service
        assign hw_set = edge_mode_i[i] ? (irq_i[i] & ~irq_q[i])
                                       : (irq_i[i] & ~act_i[i] & ~ack_hit_i[i]);

        always_ff @(posedge clk) begin
            if (rst) pend_o[i] <= 1'b0;
            else     pend_o[i] <= (pend_o[i] & ~sw_clr_i[i] & ~ack_hit_i[i])
                                  | hw_set | sw_set_i[i];
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int unsigned N  = 96,
    parameter int unsigned VW = 7
) (
    input  logic [N-1:0]  elig_i,
    input  prio_t         prio_i [N],
    output logic          valid_o,
    output logic [VW-1:0] idx_o,
    output prio_t         prio_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '1;
        // strict compare keeps the lower index on a tie
        for (int i = 0; i < int'(N); i++) begin
            if (elig_i[i] && (!valid_o || (prio_i[i] < prio_o))) begin
                valid_o = 1'b1;
                prio_o  = prio_i[i];
                idx_o   = VW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned VW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [VW-1:0] push_val_i,
    input  logic          pop_i,
    output logic [VW-1:0] top_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [VW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] top_ptr;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign top_ptr = IW'(cnt_q - CW'(1));
    assign top_o   = mem[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (push_i && !full_o) begin
            mem[IW'(cnt_q)] <= push_val_i;
            cnt_q           <= cnt_q + CW'(1);
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter  int unsigned NUM_IRQ = 96,
    parameter  int unsigned STACK_D = 8,
    localparam int unsigned VEC_W   = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               nmi_i,
    input  logic               bus_we_i,
    input  logic [BUS_AW-1:0]  bus_addr_i,
    input  logic [BUS_DW-1:0]  bus_wdata_i,
    output logic [BUS_DW-1:0]  bus_rdata_o,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    input  logic               irq_ack_i,
    input  logic               irq_eoi_i
);

    localparam int unsigned NW    = (NUM_IRQ + 31) / 32;
    localparam int unsigned PAD_W = NW * 32;
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_IRQ);

    reg_sel_t           sel;
    logic [PAD_W-1:0]   wr_spread;
    logic [NUM_IRQ-1:0] en_q, act_q, pend, elig;
    logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_IRQ-1:0] ack_hit, end_hit;
    logic [PAD_W-1:0]   sense_pad;
    logic [NUM_IRQ-1:0] sense_q;
    prio_t              prio_q [NUM_IRQ];
    split_t             split_q;
    logic               nmi_q, nmi_pend_q, nmi_act_q;

    logic               cand_valid;
    logic [VEC_W-1:0]   cand_idx;
    prio_t              cand_prio, top_prio;
    logic [VEC_W-1:0]   top_idx;
    logic               stk_empty, stk_full;
    logic               preempt, mask_req, nmi_req;
    logic               take, take_nmi, take_line, end_nmi, end_line;

    // ---------------- register bus decode ----------------
    assign sel       = decode_addr(bus_addr_i);
    assign wr_spread = (sel.word < SEL_W'(NW))
                       ? (PAD_W'(bus_wdata_i) << {sel.word, 5'b00000}) : '0;

    assign en_set = (bus_we_i && sel.bank == RB_EN_SET) ? wr_spread[NUM_IRQ-1:0] : '0;
    assign en_clr = (bus_we_i && sel.bank == RB_EN_CLR) ? wr_spread[NUM_IRQ-1:0] : '0;
    assign pd_set = (bus_we_i && sel.bank == RB_PD_SET) ? wr_spread[NUM_IRQ-1:0] : '0;
    assign pd_clr = (bus_we_i && sel.bank == RB_PD_CLR) ? wr_spread[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            split_q <= '0;
        end else begin
            en_q <= (en_q | en_set) & ~en_clr;
            if (bus_we_i && sel.bank == RB_SPLIT) split_q <= bus_wdata_i[SPLIT_W-1:0];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_sense
        always_ff @(posedge clk) begin
            if (rst)
                sense_pad[w*32 +: 32] <= '0;
            else if (bus_we_i && sel.bank == RB_SENSE && int'(sel.word) == w)
                sense_pad[w*32 +: 32] <= bus_wdata_i;
        end
    end
    assign sense_q = sense_pad[NUM_IRQ-1:0];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= '0;
            else if (bus_we_i && sel.bank == RB_PRIO && int'(sel.word) == i / 4)
                prio_q[i] <= bus_wdata_i[(i % 4) * PRIO_W +: PRIO_W];
        end
    end

    // ---------------- capture ----------------
    irqc_capture #(.N(NUM_IRQ)) capture_i (
        .clk         (clk),
        .rst         (rst),
        .irq_i       (irq_i),
        .edge_mode_i (sense_q),
        .act_i       (act_q),
        .ack_hit_i   (ack_hit),
        .sw_set_i    (pd_set),
        .sw_clr_i    (pd_clr),
        .pend_o      (pend)
    );

    // ---------------- arbitration ----------------
    assign elig = pend & en_q & ~act_q;

    irqc_arbiter #(.N(NUM_IRQ), .VW(VEC_W)) arbiter_i (
        .elig_i  (elig),
        .prio_i  (prio_q),
        .valid_o (cand_valid),
        .idx_o   (cand_idx),
        .prio_o  (cand_prio)
    );

    irqc_stack #(.DEPTH(STACK_D), .VW(VEC_W)) stack_i (
        .clk        (clk),
        .rst        (rst),
        .push_i     (take_line),
        .push_val_i (cand_idx),
        .pop_i      (end_line),
        .top_o      (top_idx),
        .empty_o    (stk_empty),
        .full_o     (stk_full)
    );

    assign top_prio  = prio_q[top_idx];
    assign preempt   = stk_empty ||
                       (group_of(cand_prio, split_q) < group_of(top_prio, split_q));
    assign mask_req  = cand_valid && preempt && !stk_full && !nmi_act_q;
    assign nmi_req   = nmi_pend_q && !nmi_act_q;

    assign irq_req_o = nmi_req || mask_req;
    assign irq_vec_o = nmi_req ? NMI_VEC : cand_idx;

    // ---------------- service tracking ----------------
    assign take      = irq_ack_i && irq_req_o;
    assign take_nmi  = take && nmi_req;
    assign take_line = take && !nmi_req;
    assign end_nmi   = irq_eoi_i && !irq_ack_i && nmi_act_q;
    assign end_line  = irq_eoi_i && !irq_ack_i && !nmi_act_q && !stk_empty;

    assign ack_hit = take_line ? (NUM_IRQ'(1) << cand_idx) : '0;
    assign end_hit = end_line  ? (NUM_IRQ'(1) << top_idx)  : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= '0;
            nmi_q      <= 1'b0;
            nmi_pend_q <= 1'b0;
            nmi_act_q  <= 1'b0;
        end else begin
            act_q      <= (act_q | ack_hit) & ~end_hit;
            nmi_q      <= nmi_i;
            nmi_pend_q <= (nmi_pend_q && !take_nmi) || (nmi_i && !nmi_q);
            nmi_act_q  <= (nmi_act_q && !end_nmi) || take_nmi;
        end
    end

    // ---------------- read port ----------------
    logic [PAD_W-1:0] en_pad, pend_pad, act_pad;
    assign en_pad   = PAD_W'(en_q);
    assign pend_pad = PAD_W'(pend);
    assign act_pad  = PAD_W'(act_q);

    always_comb begin
        bus_rdata_o = '0;
        case (sel.bank)
            RB_EN_SET, RB_EN_CLR:
                if (sel.word < SEL_W'(NW)) bus_rdata_o = en_pad[{sel.word, 5'b00000} +: 32];
            RB_PD_SET, RB_PD_CLR:
                if (sel.word < SEL_W'(NW)) bus_rdata_o = pend_pad[{sel.word, 5'b00000} +: 32];
            RB_ACT:
                if (sel.word < SEL_W'(NW)) bus_rdata_o = act_pad[{sel.word, 5'b00000} +: 32];
            RB_SENSE:
                if (sel.word < SEL_W'(NW)) bus_rdata_o = sense_pad[{sel.word, 5'b00000} +: 32];
            RB_PRIO:
                for (int b = 0; b < 4; b++) begin
                    if ((int'(sel.word) * 4 + b) < int'(NUM_IRQ))
                        bus_rdata_o[b*PRIO_W +: PRIO_W] = prio_q[int'(sel.word) * 4 + b];
                end
            RB_SPLIT:
                bus_rdata_o = BUS_DW'(split_q);
            default:
                bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 96,
    parameter int unsigned VEC_W   = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_req_o,
    input logic [VEC_W-1:0]   irq_vec_o,
    input logic               irq_ack_i,
    input logic               irq_eoi_i,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] act_q,
    input logic               nmi_act_q,
    input logic               stk_empty,
    input logic [VEC_W-1:0]   top_idx,
    input prio_t              cand_prio,
    input prio_t              top_prio,
    input split_t             split_q
);

    localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NUM_IRQ);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_req_o);

    // R2
    no_active_request_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && irq_vec_o < NMI_V) |-> !act_q[irq_vec_o]);

    // R3
    enabled_request_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && irq_vec_o < NMI_V) |-> en_q[irq_vec_o]);

    // R7
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && irq_ack_i && irq_vec_o < NMI_V) |=> act_q[$past(irq_vec_o)]);

    // R8
    eoi_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_eoi_i && !irq_ack_i && !nmi_act_q && !stk_empty) |=> !act_q[$past(top_idx)]);

    // R10
    group_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && irq_vec_o < NMI_V && !stk_empty)
        |-> (group_of(cand_prio, split_q) < group_of(top_prio, split_q)));

    // R11
    nmi_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_act_q && irq_req_o) |-> (irq_vec_o == NMI_V));

endmodule

bind irqc_top irqc_checker #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) checker_i (
    .clk       (clk),
    .rst       (rst),
    .irq_req_o (irq_req_o),
    .irq_vec_o (irq_vec_o),
    .irq_ack_i (irq_ack_i),
    .irq_eoi_i (irq_eoi_i),
    .en_q      (en_q),
    .act_q     (act_q),
    .nmi_act_q (nmi_act_q),
    .stk_empty (stk_empty),
    .top_idx   (top_idx),
    .cand_prio (cand_prio),
    .top_prio  (top_prio),
    .split_q   (split_q)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    localparam int NIRQ = 96;
    localparam int NMIV = 96;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] irq = '0;
    logic        nmi = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;
    logic [6:0]  vec;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqc_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_i       (irq),
        .nmi_i       (nmi),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_req_o   (req),
        .irq_vec_o   (vec),
        .irq_ack_i   (ack),
        .irq_eoi_i   (eoi)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic req_chk(string tag, bit exp_req, int exp_vec);
        logic [7:0] got, exp;
        #1;
        got = req ? {1'b1, vec} : 8'h00;
        exp = exp_req ? {1'b1, 7'(exp_vec)} : 8'h00;
        chk(tag, 32'(got), 32'(exp));
    endtask

    function automatic logic [11:0] wa(int base, int line);
        return 12'(base + 4 * (line / 32));
    endfunction

    function automatic logic [31:0] bitw(int line);
        return 32'h1 << (line % 32);
    endfunction

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    task automatic en_all(bit on);
        for (int w = 0; w < 3; w++) wr(12'((on ? 'h100 : 'h180) + 4 * w), 32'hFFFF_FFFF);
    endtask

    task automatic clr_pend_all();
        for (int w = 0; w < 3; w++) wr(12'('h280 + 4 * w), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cands [8] = '{8'h00, 8'h20, 8'h38, 8'h3F, 8'h40, 8'h41, 8'h80, 8'hFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int w = 0; w < 3; w++) begin
            rd_chk("R1 enable", 12'('h100 + 4 * w), 32'h0);
            rd_chk("R1 pending", 12'('h200 + 4 * w), 32'h0);
            rd_chk("R1 active", 12'('h300 + 4 * w), 32'h0);
            rd_chk("R1 sense", 12'('h380 + 4 * w), 32'h0);
        end
        for (int w = 0; w < 24; w++) rd_chk("R1 priority", 12'('h400 + 4 * w), 32'h0);
        rd_chk("R1 split", 12'h010, 32'h0);
        req_chk("R1 request", 1'b0, 0);

        // R3: enable set/clear banks
        wr(12'h104, 32'hA5A5_0F0F);
        rd_chk("R3 set-bank read", 12'h104, 32'hA5A5_0F0F);
        rd_chk("R3 clear-bank read", 12'h184, 32'hA5A5_0F0F);
        wr(12'h184, 32'h0000_000F);
        rd_chk("R3 clear bits", 12'h104, 32'hA5A5_0F00);
        wr(12'h104, 32'h0);
        rd_chk("R3 zero write", 12'h104, 32'hA5A5_0F00);
        rd_chk("R3 other word", 12'h100, 32'h0);
        wr(12'h184, 32'hFFFF_FFFF);

        // R4: pending set/clear banks; R3 disabled line not requested
        wr(12'h208, 32'h8000_0001);
        rd_chk("R4 set pending", 12'h208, 32'h8000_0001);
        wr(12'h288, 32'h0000_0001);
        rd_chk("R4 clear pending", 12'h288, 32'h8000_0000);
        req_chk("R3 disabled pending", 1'b0, 0);
        wr(12'h108, 32'h8000_0000);
        req_chk("R3 enabled pending", 1'b1, 95);
        clr_pend_all();
        wr(12'h188, 32'hFFFF_FFFF);

        // R2: each line alone yields its own vector
        en_all(1'b1);
        for (int i = 0; i < NIRQ; i++) begin
            wr(wa('h200, i), bitw(i));
            req_chk("R2 single line", 1'b1, i);
            wr(wa('h280, i), bitw(i));
        end
        req_chk("R2 idle", 1'b0, 0);

        // R2/R9: full priority sweep of line 10 against line 40 at 128
        wr(12'h428, 32'h0000_0080);
        wr(wa('h200, 10), bitw(10));
        wr(wa('h200, 40), bitw(40));
        for (int p = 0; p < 256; p++) begin
            wr(12'h408, 32'(p) << 16);
            req_chk("R2 priority sweep", 1'b1, (p <= 128) ? 10 : 40);
        end
        wr(12'h408, 32'h0);
        wr(12'h428, 32'h0);
        req_chk("R2 tie lower index", 1'b1, 10);
        clr_pend_all();

        // R9: byte lanes of a priority word
        wr(12'h404, 32'h1122_3344);
        rd_chk("R9 readback", 12'h404, 32'h1122_3344);
        wr(12'h200, 32'h0000_00F0);
        req_chk("R9 lane 3 most urgent", 1'b1, 7);
        wr(12'h280, 32'h0000_0080);
        req_chk("R9 lane 2 next", 1'b1, 6);
        wr(12'h280, 32'h0000_0040);
        req_chk("R9 lane 1 next", 1'b1, 5);
        clr_pend_all();
        wr(12'h404, 32'h0);

        // R7/R8: acknowledge and end of interrupt
        wr(12'h200, 32'h0000_0008);
        req_chk("R7 before ack", 1'b1, 3);
        pulse_ack();
        rd_chk("R7 active set", 12'h300, 32'h0000_0008);
        rd_chk("R7 pending cleared", 12'h200, 32'h0);
        req_chk("R7 no request", 1'b0, 0);
        wr(12'h300, 32'h0);
        rd_chk("R7 active read-only", 12'h300, 32'h0000_0008);
        pulse_eoi();
        rd_chk("R8 active cleared", 12'h300, 32'h0);
        wr(12'h300, 32'hFFFF_FFFF);
        rd_chk("R7 active write ignored", 12'h300, 32'h0);

        // R10: split sweep, active line 3 at 0x40, candidate line 2
        wr(12'h400, 32'h4000_0000);
        wr(12'h200, 32'h0000_0008);
        pulse_ack();
        wr(12'h200, 32'h0000_0004);
        for (int s = 0; s < 8; s++) begin
            wr(12'h010, 32'(s));
            rd_chk("R10 split readback", 12'h010, 32'(s));
            foreach (cands[k]) begin
                bit exp_pre;
                wr(12'h400, 32'h4000_0000 | (32'(cands[k]) << 16));
                exp_pre = (int'(cands[k]) >> s) < (int'(8'h40) >> s);
                req_chk("R10 group preemption", exp_pre, 2);
            end
        end
        wr(12'h280, 32'h0000_0004);
        pulse_eoi();
        wr(12'h010, 32'h0);
        wr(12'h400, 32'h0);
        rd_chk("R8 split test cleanup", 12'h300, 32'h0);

        // R5: level line 20
        irq[20] = 1'b1;
        tick();
        rd_chk("R5 level pends", 12'h200, bitw(20));
        req_chk("R5 level request", 1'b1, 20);
        pulse_ack();
        tick();
        rd_chk("R5 no pend while active", 12'h200, 32'h0);
        pulse_eoi();
        tick();
        rd_chk("R5 re-pend after eoi", 12'h200, bitw(20));
        rd_chk("R5 active cleared", 12'h300, 32'h0);
        irq[20] = 1'b0;
        wr(12'h280, bitw(20));
        tick();
        rd_chk("R5 low stays clear", 12'h200, 32'h0);

        // R6: edge line 21
        wr(12'h380, bitw(21));
        rd_chk("R6 sense readback", 12'h380, bitw(21));
        irq[21] = 1'b1;
        tick();
        rd_chk("R6 edge pends", 12'h200, bitw(21));
        pulse_ack();
        tick();
        tick();
        rd_chk("R6 held high no re-pend", 12'h200, 32'h0);
        irq[21] = 1'b0;
        tick();
        irq[21] = 1'b1;
        tick();
        rd_chk("R6 edge while active", 12'h200, bitw(21));
        req_chk("R6 active not requested", 1'b0, 0);
        pulse_eoi();
        req_chk("R6 kept edge requested", 1'b1, 21);
        irq[21] = 1'b0;
        wr(12'h280, bitw(21));
        wr(12'h380, 32'h0);

        // R11: non-maskable input
        wr(wa('h200, 30), bitw(30));
        req_chk("R11 maskable first", 1'b1, 30);
        nmi = 1'b1;
        tick();
        req_chk("R11 nmi wins", 1'b1, NMIV);
        en_all(1'b0);
        req_chk("R11 not maskable", 1'b1, NMIV);
        en_all(1'b1);
        pulse_ack();
        nmi = 1'b0;
        req_chk("R11 exclusive service", 1'b0, 0);
        pulse_eoi();
        req_chk("R11 maskable after eoi", 1'b1, 30);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule